// File: doc/BRIEF.md
# Parallel Configuration Host Controller

This block sits on the host side of a chain of configurable logic devices and loads them through a byte-wide passive parallel port. On a start request it drives the shared active-low configuration-start line low for a programmable number of clocks and then releases it. It then waits, with a timeout, for the shared open-drain status line to go high. After that it streams the image one byte per data-clock pulse.

The bytes are fetched from an external memory with one cycle of read latency. The fetch starts at a base address and covers a given byte count. The chain passes control from one device to the next by itself, so the host streams one continuous image with no per-device framing and no addressing of individual devices.

Completion is signalled when the shared wired-AND done line rises. If the image runs out before that, the host sends a programmable number of extra clock pulses. A low status line during loading, or a status timeout, restarts the whole chain from the first byte, up to a retry limit. The configuration inputs must stay stable while `busy` is high.

Top module: `pcfg_host`

## Requirements
- R1: After reset, `cfg_start_n` is 1, `dclk` is 0, `mem_rd` is 0, and `busy`, `done` and `error` are all 0.
- R2: After `start`, `cfg_start_n` is held low for exactly `pulse_len` consecutive clocks (minimum 1) and then released. It is low only while `busy` is 1.
- R3: No data-clock pulse is issued until the status line has been seen high. If the status line stays low for more than `status_timeout` clocks after release, this counts as an error.
- R4: The n-th image byte, with n counting from 0, is the memory byte at `base_addr + n`. It is presented on `data` in the clock before `dclk` rises and is held unchanged in the clock after `dclk` falls.
- R5: `dclk` is high for exactly one clock per pulse, and exactly one pulse is issued per image byte.
- R6: When `chain_done` is high during loading, the block enters the finished state: `done`=1, `busy`=0, `error`=0. It issues no further `dclk` pulses.
- R7: A low status line during loading, or a status timeout, restarts configuration with a new start pulse and streaming from `base_addr`, as long as fewer than `max_retries` restarts have been used.
- R8: An error that occurs after `max_retries` restarts ends the run with `error`=1, `busy`=0 and `done`=0.
- R9: When all bytes have been sent and `chain_done` is still low, up to `extra_clocks` further `dclk` pulses are issued. If done rises during them, the run finishes as in R6.
- R10: When the extra pulses are used up and `chain_done` is still low, the run ends with `error`=1.
- R11: `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration run (when not busy) |
| base_addr | input | AW | First memory address of the image |
| byte_count | input | AW | Image length in bytes |
| pulse_len | input | CW | Start-line low time in clocks |
| status_timeout | input | CW | Maximum clocks to wait for the status line |
| extra_clocks | input | CW | Extra data-clock pulses after the image |
| max_retries | input | RW | Automatic restarts allowed |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_data | input | 8 | Memory read data, valid one clock after `mem_rd` |
| cfg_start_n | output | 1 | Shared active-low configuration-start line |
| chain_status | input | 1 | Shared status line, low means reset or error |
| chain_done | input | 1 | Shared wired-AND done line |
| dclk | output | 1 | Data clock to the chain |
| data | output | 8 | Configuration data byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | Chain configured |
| error | output | 1 | Run failed |

## Verification
The bench models the chain. It raises status a set delay after release, raises done after a set number of pulses, and can pull status low after a chosen pulse in the first few attempts. Errors injected twice in a row check that each restart goes back to `base_addr`; a design that resumed at the failing byte would feed the scoreboard the wrong bytes. Runs where done rises partway through the extra pulses, or never rises, catch an off-by-one in the flush count as a wrong total pulse count or a wrong final flag. A status line that never rises and a start pulse sent mid-run catch a host that hangs on the timeout or restarts when it should not, by the number of start pulses seen.

// File: rtl/pcfg_host.sv
module pcfg_host #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] byte_count,
  input  logic [CW-1:0] pulse_len,
  input  logic [CW-1:0] status_timeout,
  input  logic [CW-1:0] extra_clocks,
  input  logic [RW-1:0] max_retries,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_data,
  output logic          cfg_start_n,
  input  logic          chain_status,
  input  logic          chain_done,
  output logic          dclk,
  output logic [7:0]    data,
  output logic          busy,
  output logic          done,
  output logic          error
);

  typedef enum logic [3:0] {
    S_IDLE, S_PULSE, S_WAIT, S_FETCH, S_LOAD, S_SETUP,
    S_HIGH, S_HOLD, S_FLO, S_FHI, S_DONE, S_FAIL
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr, left;
  logic [7:0]    dq;
  logic [RW-1:0] tries;

  wire loading  = st inside {S_FETCH, S_LOAD, S_SETUP, S_HIGH, S_HOLD, S_FLO, S_FHI};
  wire timeout  = (st == S_WAIT) && !chain_status && (cnt >= status_timeout);
  wire fault    = (loading && !chain_status) || timeout;
  wire retry_ok = tries < max_retries;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      addr  <= '0;
      left  <= '0;
      dq    <= '0;
      tries <= '0;
    end else if (loading && chain_done) begin
      st <= S_DONE;
    end else if (fault) begin
      if (retry_ok) begin
        tries <= tries + RW'(1);
        st    <= S_PULSE;
        cnt   <= '0;
      end else begin
        st <= S_FAIL;
      end
    end else begin
      case (st)
        S_IDLE, S_DONE, S_FAIL:
          if (start) begin
            st    <= S_PULSE;
            cnt   <= '0;
            tries <= '0;
          end
        S_PULSE: begin
          addr <= base_addr;
          left <= byte_count;
          if (cnt + CW'(1) >= pulse_len) begin
            st  <= S_WAIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_WAIT:
          if (chain_status) begin
            st  <= (left == '0) ? S_FLO : S_FETCH;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        S_FETCH: st <= S_LOAD;
        S_LOAD: begin
          dq   <= mem_data;
          addr <= addr + AW'(1);
          left <= left - AW'(1);
          st   <= S_SETUP;
        end
        S_SETUP: st <= S_HIGH;
        S_HIGH:  st <= S_HOLD;
        S_HOLD:
          if (left == '0) begin
            st  <= S_FLO;
            cnt <= '0;
          end else begin
            st <= S_FETCH;
          end
        S_FLO: st <= (cnt >= extra_clocks) ? S_FAIL : S_FHI;
        S_FHI: begin
          cnt <= cnt + CW'(1);
          st  <= S_FLO;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd      = (st == S_FETCH);
  assign mem_addr    = addr;
  assign data        = dq;
  assign dclk        = (st == S_HIGH) || (st == S_FHI);
  assign cfg_start_n = (st != S_PULSE);
  assign busy        = !(st inside {S_IDLE, S_DONE, S_FAIL});
  assign done        = (st == S_DONE);
  assign error       = (st == S_FAIL);

  assert_start_low_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_start_n |-> busy);
  assert_dclk_after_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> $past(chain_status));
  assert_data_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> $stable(data));
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dclk) |-> $stable(data));
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |=> !dclk);
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, error}));
  assert_no_dclk_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !dclk && cfg_start_n);

endmodule

// File: tb/pcfg_host_test.sv
module pcfg_host_test;
  localparam int AW = 16, CW = 16, RW = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = 0, byte_count = 0;
  logic [CW-1:0] pulse_len = 1, status_timeout = 1, extra_clocks = 0;
  logic [RW-1:0] max_retries = 0;
  logic mem_rd, cfg_start_n, dclk, busy, done, error;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data = 0, data;
  logic chain_status = 0, chain_done = 0;

  int vectors = 0, fails = 0, cycles = 0;
  int status_delay, done_at, err_at, err_times;
  int dly, pulses_m, inj_used;
  bit faulted;
  int attempts, total_pulses, lowcnt;
  bit done_seen;
  logic [7:0] exp_q[$], work_q[$];

  always #2.5 clk = ~clk;

  pcfg_host #(.AW(AW), .CW(CW), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .byte_count(byte_count), .pulse_len(pulse_len), .status_timeout(status_timeout),
    .extra_clocks(extra_clocks), .max_retries(max_retries), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data), .cfg_start_n(cfg_start_n),
    .chain_status(chain_status), .chain_done(chain_done), .dclk(dclk), .data(data),
    .busy(busy), .done(done), .error(error));

  function automatic logic [7:0] img(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (mem_rd) mem_data <= img(int'(mem_addr));

  // chain model
  always @(posedge clk) begin
    if (!rst_n) begin
      inj_used <= 0; dly <= 0; pulses_m <= 0; faulted <= 0;
      chain_status <= 0; chain_done <= 0;
    end else if (!cfg_start_n) begin
      dly <= 0; pulses_m <= 0; faulted <= 0; chain_status <= 0; chain_done <= 0;
    end else begin
      automatic bit hit = dclk && (inj_used < err_times) && (pulses_m + 1 == err_at) && !faulted;
      automatic bit f = faulted || hit;
      if (dclk) pulses_m <= pulses_m + 1;
      if (hit) begin faulted <= 1; inj_used <= inj_used + 1; end
      if (dly < status_delay) dly <= dly + 1;
      chain_status <= (dly >= status_delay) && !f;
      chain_done <= !f && ((pulses_m + (dclk ? 1 : 0)) >= done_at);
    end
  end

  // monitor / scoreboard
  logic prev_start_n = 1, prev_dclk = 0;
  logic [7:0] prev_data = 0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (prev_start_n && !cfg_start_n) begin
        attempts++;
        work_q = exp_q;
      end
      if (!cfg_start_n) lowcnt++;
      if (!prev_start_n && cfg_start_n) begin
        check(lowcnt == int'(pulse_len), "R2 start pulse width", lowcnt, int'(pulse_len));
        lowcnt = 0;
      end
      if (dclk && !prev_dclk) begin
        total_pulses++;
        check(data == prev_data, "R4 setup", data, prev_data);
        check(!done_seen, "R6 pulse after done", 1, 0);
        if (work_q.size() > 0) begin
          automatic logic [7:0] e = work_q.pop_front();
          check(data == e, "R4 byte order", data, e);
        end
      end
      if (prev_dclk && !dclk) check(data == prev_data, "R4 hold", data, prev_data);
      if (done) done_seen = 1;
    end
    prev_start_n = cfg_start_n;
    prev_dclk = dclk;
    prev_data = data;
    if (cycles > 150000) begin
      fails++; vectors++;
      $display("FAIL watchdog: got %0d expected 0", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic run(input int base, input int cnt, input int pl, input int tmo, input int ext,
                     input int rtr, input int sdly, input int dat, input int eat, input int etm,
                     input bit mid_start);
    @(negedge clk);
    rst_n = 0;
    base_addr = AW'(base); byte_count = AW'(cnt); pulse_len = CW'(pl);
    status_timeout = CW'(tmo); extra_clocks = CW'(ext); max_retries = RW'(rtr);
    status_delay = sdly; done_at = dat; err_at = eat; err_times = etm;
    exp_q.delete();
    for (int i = 0; i < cnt; i++) exp_q.push_back(img(base + i));
    attempts = 0; total_pulses = 0; lowcnt = 0; done_seen = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    if (mid_start) begin
      repeat (30) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int g = 0; g < 20000 && !(done || error); g++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    status_delay = 0; done_at = 1000; err_at = 0; err_times = 0;
    repeat (3) @(negedge clk);
    check(cfg_start_n === 1 && dclk === 0 && mem_rd === 0 && busy === 0 && done === 0 && error === 0,
          "R1 reset state", {cfg_start_n, dclk, mem_rd, busy, done, error}, 6'b100000);

    // R5 R6 normal load
    run(16'h100, 12, 4, 50, 5, 0, 5, 12, 0, 0, 0);
    check(done && !busy && !error, "R6 finished flags", {busy, done, error}, 3'b010);
    check(total_pulses == 12, "R5 one pulse per byte", total_pulses, 12);
    check(attempts == 1, "R2 single attempt", attempts, 1);

    // R9 done rises during flush
    run(16'h20, 6, 2, 50, 5, 0, 3, 8, 0, 0, 0);
    check(done && !error, "R9 done in flush", {done, error}, 2'b10);
    check(total_pulses == 8, "R9 flush pulse count", total_pulses, 8);

    // R10 flush exhausted
    run(16'h40, 4, 2, 50, 3, 0, 3, 1000, 0, 0, 0);
    check(error && !done && !busy, "R10 fail flags", {busy, done, error}, 3'b001);
    check(total_pulses == 7, "R10 total pulses", total_pulses, 7);

    // R7 restart from base after errors
    run(16'h300, 8, 3, 50, 2, 2, 4, 8, 3, 2, 0);
    check(done && !error, "R7 recovered", {done, error}, 2'b10);
    check(attempts == 3, "R7 attempts", attempts, 3);
    check(total_pulses == 14, "R7 pulses over attempts", total_pulses, 14);

    // R8 retries exhausted
    run(16'h300, 8, 3, 50, 2, 1, 4, 8, 3, 5, 0);
    check(error && !done && !busy, "R8 fail flags", {busy, done, error}, 3'b001);
    check(attempts == 2, "R8 attempts", attempts, 2);

    // R3 status timeout
    run(16'h0, 4, 2, 10, 2, 1, 100000, 4, 0, 0, 0);
    check(error && !done, "R3 timeout error", {done, error}, 2'b01);
    check(attempts == 2, "R3 timeout retried", attempts, 2);
    check(total_pulses == 0, "R3 no pulse before status", total_pulses, 0);

    // R11 start while busy
    run(16'h500, 10, 2, 50, 2, 0, 2, 10, 0, 0, 1);
    check(done && !error, "R11 run completes", {done, error}, 2'b10);
    check(attempts == 1, "R11 start ignored", attempts, 1);
    check(total_pulses == 10, "R11 pulses", total_pulses, 10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule